// File: doc/BRIEF.md
# Frame-Parallel FIR Filter

This block is a fixed-coefficient FIR filter that consumes a whole frame of M consecutive input samples on each accepted clock and produces the M matching output samples. The coefficients are split into M interleaved subfilters: the subfilter with phase k holds taps k, k+M, k+2M and so on. Each output position gets the products of every subfilter it needs, and those products meet in a pipelined adder tree. A short history of past frames supplies the older samples that the longer taps reach back to.

The data path is a stream with a valid/ready handshake on each side. The whole pipeline advances as one unit. It moves on every clock in which the output stage is empty or the consumer takes the output word. When the consumer holds `out_ready` low while a result waits, every stage freezes, including the frame history. The same condition drops `in_ready`, so no input frame is accepted until the output moves. Register stages can be placed at the multiplier inputs, at the multiplier outputs, and between adder-tree levels. All arithmetic keeps full precision.

Top module: `frame_fir`

## Requirements
- R1: A frame is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Sample position p of the frame, at bits `[p*DW +: DW]`, is later in time than position p-1, and position 0 comes first.
- R2: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` keep their values on the next clock.
- R3: Output position p of frame n, at bits `[p*OW +: OW]`, equals the sum over taps j of c[j]·x[nM+p−j]. Here x is the sequence of samples accepted since reset, and samples before the first one count as zero. Clocks with no accepted frame leave this sequence unchanged, whatever is on `in_data`.
- R4: Output samples are signed with OW = DW + CW + ceil(log2(NTAPS)) bits. They never wrap, including when inputs and coefficients are at their largest magnitudes.
- R5: With `out_ready` held high, the result of a frame is presented LATENCY = MUL_IN_STAGES + MUL_OUT_STAGES + TREE_STAGES·ceil(log2(NTAPS)) clocks after its acceptance edge. With the default parameters this is 8.
- R6: Exactly one output word is delivered for each accepted frame, and words leave in acceptance order.
- R7: While `rst` is high, and on the clock after it, `out_valid` is low and `in_ready` is high. After reset all earlier samples read as zero.
- R8: Tap j is the signed two's-complement value at `COEFS[j*CW +: CW]`. Input samples are signed two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Filter can take a frame this clock |
| in_data | input | M*DW | Input frame, position 0 in the low bits |
| out_valid | output | 1 | Output frame present |
| out_ready | input | 1 | Consumer takes the output frame this clock |
| out_data | output | M*OW | Output frame, position 0 in the low bits |

## Verification
The hardest case to reach from the ports is a stall that hits while the pipeline is full and the input side still has frames to offer. The output has to freeze, the history must not advance, and the in-flight words must then resume with no loss or duplication. The stimulus gets there in a random phase. It withholds `out_ready` on about a quarter of the clocks and leaves idle gaps with junk on `in_data`. A reference convolution model, fed only with the frames the handshake actually accepted, checks every word.

Separate cases cover other paths. A run with no stalls checks the exact latency. A reset arrives while frames are still in flight. Sign-matched extreme inputs drive the sum to its largest positive and negative values.

// File: rtl/frame_fir_pkg.sv
package frame_fir_pkg;

  // number of whole past frames needed to reach the oldest tap
  function automatic int past_frames(input int taps, input int m);
    return (taps - 1 + m - 1) / m;
  endfunction

  // slot of sample x[t-j] in the window (oldest slot 0) for output position p
  function automatic int window_slot(input int past, input int m, input int p, input int j);
    return past * m + p - j;
  endfunction

  // full precision width of the sum of taps products
  function automatic int full_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/fir_pipe_delay.sv
module fir_pipe_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [0:DEPTH-1];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (en) begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fir_frame_history.sv
module fir_frame_history #(
  parameter int M    = 2,
  parameter int DW   = 8,
  parameter int PAST = 3,
  localparam int FW  = M * DW,
  localparam int WW  = (PAST + 1) * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [FW-1:0] frame_in,
  output logic [WW-1:0] window
);
  generate
    if (PAST == 0) begin : g_none
      assign window = frame_in;
    end else begin : g_hist
      logic [PAST*FW-1:0] past_q;
      if (PAST == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst)       past_q <= '0;
          else if (push) past_q <= frame_in;
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst)       past_q <= '0;
          else if (push) past_q <= {frame_in, past_q[PAST*FW-1:FW]};
        end
      end
      // oldest frame in the low bits, the live frame on top
      assign window = {frame_in, past_q};
    end
  endgenerate
endmodule

// File: rtl/fir_adder_tree.sv
module fir_adder_tree #(
  parameter int N      = 6,
  parameter int IW     = 16,
  parameter int OW     = 19,
  parameter int STAGES = 2,
  localparam int LV    = $clog2(N),
  localparam int P     = 1 << LV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [N*IW-1:0] terms,
  output logic [OW-1:0] sum
);
  logic signed [OW-1:0] lvl [0:LV][0:P-1];

  generate
    for (genvar i = 0; i < P; i++) begin : g_leaf
      if (i < N) begin : g_term
        assign lvl[0][i] = OW'($signed(terms[i*IW +: IW]));
      end else begin : g_pad
        assign lvl[0][i] = '0;
      end
    end

    for (genvar l = 0; l < LV; l++) begin : g_level
      for (genvar i = 0; i < P; i++) begin : g_node
        if (i < (P >> (l + 1))) begin : g_add
          logic [OW-1:0] pair;
          logic [OW-1:0] pair_q;
          assign pair = lvl[l][2*i] + lvl[l][2*i+1];
          fir_pipe_delay #(.W(OW), .DEPTH(STAGES)) u_stage (
            .clk(clk), .rst(rst), .en(en), .d(pair), .q(pair_q)
          );
          assign lvl[l+1][i] = pair_q;
        end else begin : g_idle
          assign lvl[l+1][i] = '0;
        end
      end
    end
  endgenerate

  assign sum = lvl[LV][0];
endmodule

// File: rtl/frame_fir.sv
module frame_fir
  import frame_fir_pkg::*;
#(
  parameter int M              = 2,
  parameter int NTAPS          = 6,
  parameter int DW             = 8,
  parameter int CW             = 8,
  parameter logic [NTAPS*CW-1:0] COEFS = 48'h7F80_4019_F903,
  parameter int MUL_IN_STAGES  = 1,
  parameter int MUL_OUT_STAGES = 1,
  parameter int TREE_STAGES    = 2,
  localparam int PAST    = past_frames(NTAPS, M),
  localparam int SLOTS   = (PAST + 1) * M,
  localparam int PW      = DW + CW,
  localparam int OW      = full_width(DW, CW, NTAPS),
  localparam int LATENCY = MUL_IN_STAGES + MUL_OUT_STAGES + TREE_STAGES * $clog2(NTAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [M*DW-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [M*OW-1:0] out_data
);
  logic advance;
  logic push;
  logic [SLOTS*DW-1:0] window;
  logic [SLOTS*DW-1:0] mul_win;

  // whole pipeline steps together; it stands still only for a refused output
  assign advance  = out_ready | ~out_valid;
  assign in_ready = advance;
  assign push     = in_valid & advance;

  fir_frame_history #(.M(M), .DW(DW), .PAST(PAST)) u_hist (
    .clk(clk), .rst(rst), .push(push), .frame_in(in_data), .window(window)
  );

  fir_pipe_delay #(.W(SLOTS*DW), .DEPTH(MUL_IN_STAGES)) u_mul_in (
    .clk(clk), .rst(rst), .en(advance), .d(window), .q(mul_win)
  );

  fir_pipe_delay #(.W(1), .DEPTH(LATENCY)) u_valid (
    .clk(clk), .rst(rst), .en(advance), .d(in_valid), .q(out_valid)
  );

  generate
    for (genvar p = 0; p < M; p++) begin : g_pos
      logic [NTAPS*PW-1:0] terms;
      for (genvar j = 0; j < NTAPS; j++) begin : g_tap
        localparam int SLOT = window_slot(PAST, M, p, j);
        logic signed [PW-1:0] prod;
        logic [PW-1:0] prod_q;
        assign prod = PW'($signed(mul_win[SLOT*DW +: DW])) *
                      PW'($signed(COEFS[j*CW +: CW]));
        fir_pipe_delay #(.W(PW), .DEPTH(MUL_OUT_STAGES)) u_mul_out (
          .clk(clk), .rst(rst), .en(advance), .d(prod), .q(prod_q)
        );
        assign terms[j*PW +: PW] = prod_q;
      end
      fir_adder_tree #(.N(NTAPS), .IW(PW), .OW(OW), .STAGES(TREE_STAGES)) u_tree (
        .clk(clk), .rst(rst), .en(advance), .terms(terms), .sum(out_data[p*OW +: OW])
      );
    end
  endgenerate
endmodule

// File: rtl/frame_fir_checker.sv
module frame_fir_checker #(
  parameter int M     = 2,
  parameter int NTAPS = 6,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int OW    = 19
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [M*OW-1:0] out_data
);
  localparam longint BOUND = longint'(NTAPS) << (DW + CW - 2);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_empty_ready_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  generate
    for (genvar p = 0; p < M; p++) begin : g_rng
      assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'($signed(out_data[p*OW +: OW])) <= BOUND &&
                       longint'($signed(out_data[p*OW +: OW])) >= -BOUND));
    end
  endgenerate
endmodule

bind frame_fir frame_fir_checker #(
  .M(M), .NTAPS(NTAPS), .DW(DW), .CW(CW), .OW(OW)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_frame_fir.sv
module sim_frame_fir;
  localparam int M = 2, N = 6, DW = 8, CW = 8, OW = 19, LAT = 8;
  localparam logic [N*CW-1:0] CPK = 48'h7F80_4019_F903;
  localparam int C [0:N-1] = '{3, -7, 25, 64, -128, 127};
  localparam int NSTIM = 30;
  // impulse, mixed values, then sign-matched largest positive and negative sums
  localparam int STIM [0:NSTIM-1] = '{
    1, 0, 0, 0, 0, 0, 0, 0,
    5, -3, 100, -100, 127, -128, 127, 127, -128, 127,
    127, -128, 127, 127, -128, 127,
    -128, 127, -128, -128, 127, -128};

  logic clk = 0, rst = 1, in_valid = 0, out_ready = 0;
  logic [M*DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [M*OW-1:0] out_data;

  frame_fir #(.M(M), .NTAPS(N), .DW(DW), .CW(CW), .COEFS(CPK),
              .MUL_IN_STAGES(1), .MUL_OUT_STAGES(1), .TREE_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, iter = 0, nx = 0, wr = 0, rd = 0;
  bit done = 0, lat_mode = 0, hold_pend = 0;
  logic [M*OW-1:0] held;
  int xs [0:4095];
  longint expv [0:2047][0:M-1];
  int acc_it [0:2047];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model_push(input logic [M*DW-1:0] d);
    for (int p = 0; p < M; p++) xs[nx+p] = int'($signed(d[p*DW +: DW]));
    for (int p = 0; p < M; p++) begin
      longint s = 0;
      for (int j = 0; j < N; j++)
        if (nx + p - j >= 0) s += longint'(C[j]) * longint'(xs[nx+p-j]);
      expv[wr][p] = s;
    end
    acc_it[wr] = iter;
    nx += M;
    wr++;
  endtask

  task automatic step(input bit v, input logic [M*DW-1:0] d, input bit ordy, output bit acc);
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = ordy;
    #1;
    iter++;
    if (hold_pend)
      chk(out_valid && out_data == held, "R2 held output", longint'(out_data), longint'(held));
    chk(in_ready == (out_ready || !out_valid), "R2 in_ready rule", in_ready, out_ready || !out_valid);
    if (out_valid && out_ready) begin
      if (rd >= wr) chk(0, "R6 extra output", rd, wr);
      else begin
        for (int p = 0; p < M; p++) begin
          longint got = longint'($signed(out_data[p*OW +: OW]));
          chk(got == expv[rd][p], "R1 R3 R4 R8 sample", got, expv[rd][p]);
        end
        if (lat_mode) chk(iter - acc_it[rd] == LAT, "R5 latency", iter - acc_it[rd], LAT);
        rd++;
      end
    end
    hold_pend = out_valid && !out_ready;
    held = out_data;
    acc = v && in_ready;
    if (acc) model_push(d);
  endtask

  task automatic send(input logic [M*DW-1:0] d, input bit rnd);
    bit acc;
    do step(1'b1, d, rnd ? ($urandom % 4 != 0) : 1'b1, acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    for (int i = 0; i < LAT + 4; i++) step(1'b0, 16'hDEAD, 1'b1, acc);
    chk(rd == wr, "R6 frames delivered", rd, wr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = $urandom % 2;
    @(negedge clk);
    #1 chk(!out_valid && in_ready, "R7 during reset", out_valid, 0);
    @(negedge clk);
    rst = 0;
    #1 chk(!out_valid && in_ready, "R7 after reset", out_valid, 0);
    nx = 0; wr = 0; rd = 0; hold_pend = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!out_valid, "R7 reset out_valid", out_valid, 0);
    chk(in_ready, "R7 reset in_ready", in_ready, 1);
    rst = 0;
    // table walk, no stalls: exact latency
    lat_mode = 1;
    for (int f = 0; f < NSTIM / M; f++)
      send({8'(STIM[2*f+1]), 8'(STIM[2*f])}, 1'b0);
    drain();
    lat_mode = 0;
    // random traffic with stalls and idle junk
    for (int f = 0; f < 300; f++) begin
      logic [M*DW-1:0] d;
      bit acc;
      d = 16'($urandom);
      if ($urandom % 8 == 0) d = {8'h80, 8'h80};
      if ($urandom % 8 == 0) d = {8'h7F, 8'h80};
      while ($urandom % 3 == 0) step(1'b0, 16'($urandom), $urandom % 2, acc);
      send(d, 1'b1);
    end
    drain();
    // reset with frames in flight, then impulse response from clean history
    for (int f = 0; f < 4; f++) send(16'($urandom), 1'b0);
    do_reset();
    lat_mode = 1;
    send({8'd0, 8'd1}, 1'b0);
    for (int f = 0; f < 3; f++) send(16'd0, 1'b0);
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule